// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked model of the write side of a byte-wide parallel flash command interface. Each bus write carries a 19-bit address and a data byte and appears as a one-cycle strobe. The decoder follows the multi-cycle unlock-and-command sequences in this stream. When a sequence completes, it issues a one-cycle operation request to a downstream program/erase controller. The request carries the program target address and data, or the list of blocks to erase.

The decoder also holds two levels that the read path uses. One marks identification read mode, in which signature and protection-status codes are read instead of the array. The other marks the power-down condition.

Protected commands begin with a two-write unlock prefix at two coded addresses, and only the low 15 address bits are compared against those addresses. Erase needs a second unlock prefix before its confirm byte. After a block erase confirm, further block addresses are accepted during a timed window. The erase request is issued when that window closes. The controller reports busy and erase-busy levels back to the decoder, and while it is busy the decoder ignores writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset (rst_n low, released synchronously), req_valid, ident_mode and powered_down are 0. Any sequence that was partly entered is discarded. Request codes on req_op, issued with a one-cycle req_valid in the cycle after the completing write, are: 1 reset, 2 identification read, 3 program, 4 block erase, 5 chip erase, 6 suspend, 7 resume, 8 power down.
- R2: The coded addresses are compared on address bits 14:0 only: bits 14:0 must equal 5555h (first address) or 2AAAh (second address), and bits 18:15 are ignored. The unlock prefix is AAh at the first address followed by 55h at the second address.
- R3: A single write of F0h at any address, or the unlock prefix followed by F0h at the first address, issues request 1 and clears ident_mode.
- R4: The unlock prefix followed by 90h at the first address issues request 2 and sets ident_mode. ident_mode stays 1 until the next accepted write, which clears it.
- R5: The unlock prefix followed by A0h at the first address arms programming. The next accepted write, at any address, issues request 3 with req_addr and req_data equal to that write's address and data.
- R6: The unlock prefix, 80h at the first address, a second unlock prefix, then 10h at the first address issues request 5.
- R7: In that same erase sequence, 30h at any address as the sixth write opens a block window and marks the block whose index is address bits 18:16. Each later 30h write inside the window marks one more block and restarts the window. Other writes inside the window are ignored. ERASE_WINDOW cycles after the last 30h write, request 4 is issued with req_blocks bit i set for each marked block i.
- R8: A single write of B0h at any address issues request 6. A single write of 30h at any address issues request 7.
- R9: 20h at the first address as a single write issues request 8 and sets powered_down. While powered_down is 1, only the two reset forms of R3 are accepted, and they clear powered_down. Every other write issues no request and leaves ident_mode at 0.
- R10: A write that does not match the next expected write of a sequence returns the decoder to idle with no request. A following command byte is then treated as the first write of a new sequence.
- R11: While ctrl_busy is 1, writes issue no request and do not advance the sequence. The one exception is B0h while ctrl_erase_busy is 1, which issues request 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_valid | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | 19 | Address of the bus write |
| wr_data | input | 8 | Data byte of the bus write |
| ctrl_busy | input | 1 | Controller is executing a program or erase |
| ctrl_erase_busy | input | 1 | Controller is executing an erase |
| req_valid | output | 1 | One-cycle operation request strobe |
| req_op | output | 4 | Request code (see R1) |
| req_addr | output | 19 | Captured program address |
| req_data | output | 8 | Captured program data |
| req_blocks | output | 8 | Marked blocks of a block erase request |
| ident_mode | output | 1 | Identification read mode is selected instead of array read |
| powered_down | output | 1 | Power-down condition is active |

## Verification
The hardest state to reach is the block window. It needs six exactly ordered writes, then more 30h writes and foreign writes interleaved at chosen cycle offsets, and the request must land exactly ERASE_WINDOW cycles after the last marking write. The bench drives this as a directed sequence. It checks for silence one cycle before the window closes and checks the request and block mask on the closing cycle. A second hard case is a busy level that appears in the middle of an unlock prefix. The bench raises ctrl_busy between the prefix and the command byte, then drops it, and shows that the held sequence still completes. Randomized single writes and program sequences then cover the remaining byte and address space.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_RESET       = 4'd1,
    OP_SIGNATURE   = 4'd2,
    OP_PROGRAM     = 4'd3,
    OP_BLOCK_ERASE = 4'd4,
    OP_CHIP_ERASE  = 4'd5,
    OP_SUSPEND     = 4'd6,
    OP_RESUME      = 4'd7,
    OP_POWER_DOWN  = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_PROG,
    ST_ERA1,
    ST_ERA2,
    ST_ERA3,
    ST_COLLECT
  } state_e;

  localparam logic [7:0] BYTE_KEY_A   = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B   = 8'h55;
  localparam logic [7:0] BYTE_RESET   = 8'hF0;
  localparam logic [7:0] BYTE_IDENT   = 8'h90;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_ERASE   = 8'h80;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_BLOCK   = 8'h30;
  localparam logic [7:0] BYTE_SUSPEND = 8'hB0;
  localparam logic [7:0] BYTE_PDOWN   = 8'h20;

  typedef struct packed {
    logic at_first;
    logic at_second;
    logic is_key_a;
    logic is_key_b;
    logic is_reset;
    logic is_ident;
    logic is_prog;
    logic is_erase;
    logic is_chip;
    logic is_block;
    logic is_suspend;
    logic is_pdown;
  } wr_class_t;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
  import flash_cmd_pkg::*;
#(
  parameter int CODE_W = 15
) (
  input  logic [CODE_W-1:0] code_addr,
  input  logic [7:0]        data,
  output wr_class_t         cls
);

  localparam logic [CODE_W-1:0] FIRST_ADDR  = CODE_W'(15'h5555);
  localparam logic [CODE_W-1:0] SECOND_ADDR = CODE_W'(15'h2AAA);

  always_comb begin
    cls.at_first   = (code_addr == FIRST_ADDR);
    cls.at_second  = (code_addr == SECOND_ADDR);
    cls.is_key_a   = (data == BYTE_KEY_A);
    cls.is_key_b   = (data == BYTE_KEY_B);
    cls.is_reset   = (data == BYTE_RESET);
    cls.is_ident   = (data == BYTE_IDENT);
    cls.is_prog    = (data == BYTE_PROG);
    cls.is_erase   = (data == BYTE_ERASE);
    cls.is_chip    = (data == BYTE_CHIP);
    cls.is_block   = (data == BYTE_BLOCK);
    cls.is_suspend = (data == BYTE_SUSPEND);
    cls.is_pdown   = (data == BYTE_PDOWN);
  end

  always_comb begin
    assert (!(cls.at_first && cls.at_second)); // R2
  end

endmodule

// File: rtl/flash_blk_collect.sv
module flash_blk_collect #(
  parameter int NUM_BLOCKS   = 8,
  parameter int ERASE_WINDOW = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(ERASE_WINDOW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  add,
  input  logic [BLK_W-1:0]      blk_idx,
  output logic                  active,
  output logic                  done,
  output logic [NUM_BLOCKS-1:0] mask
);

  logic [NUM_BLOCKS-1:0] sel;
  logic [NUM_BLOCKS-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  active_q, active_d;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_sel
    assign sel[g] = (blk_idx == BLK_W'(g));
  end

  assign done   = active_q && !add && (cnt_q == CNT_W'(1));
  assign active = active_q;
  assign mask   = mask_q;

  always_comb begin
    mask_d   = mask_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    if (start) begin
      mask_d   = sel;
      cnt_d    = CNT_W'(ERASE_WINDOW);
      active_d = 1'b1;
    end else if (active_q) begin
      if (add) begin
        mask_d = mask_q | sel;
        cnt_d  = CNT_W'(ERASE_WINDOW);
      end else if (cnt_q == CNT_W'(1)) begin
        cnt_d    = '0;
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  AST_WINDOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q != '0); // R7
  AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active_q); // R7
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && add |=> active_q && cnt_q == CNT_W'(ERASE_WINDOW)); // R7

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int NUM_BLOCKS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  wr_class_t             cls,
  input  logic                  ctrl_busy,
  input  logic                  ctrl_erase_busy,
  input  logic                  col_done,
  input  logic [NUM_BLOCKS-1:0] col_mask,
  output logic                  col_start,
  output logic                  col_add,
  output logic                  req_valid,
  output op_e                   req_op,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [7:0]            req_data,
  output logic [NUM_BLOCKS-1:0] req_blocks,
  output logic                  ident_mode,
  output logic                  powered_down
);

  state_e                state_q, state_d;
  op_e                   op_q, op_d;
  logic                  vld_q;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic [7:0]            data_q, data_d;
  logic [NUM_BLOCKS-1:0] blk_q, blk_d;
  logic                  ident_q, ident_d;
  logic                  pd_q, pd_d;
  logic                  take;
  logic                  busy_susp;

  assign take      = wr_valid && !ctrl_busy;
  assign busy_susp = wr_valid && ctrl_busy && ctrl_erase_busy && cls.is_suspend && !pd_q;

  always_comb begin
    state_d   = state_q;
    op_d      = OP_NONE;
    addr_d    = addr_q;
    data_d    = data_q;
    blk_d     = blk_q;
    ident_d   = ident_q;
    pd_d      = pd_q;
    col_start = 1'b0;
    col_add   = 1'b0;
    if (busy_susp) begin
      op_d    = OP_SUSPEND;
      ident_d = 1'b0;
      state_d = ST_IDLE;
    end else if (state_q == ST_COLLECT) begin
      if (take && cls.is_block) begin
        col_add = 1'b1;
      end else if (col_done) begin
        op_d    = OP_BLOCK_ERASE;
        blk_d   = col_mask;
        state_d = ST_IDLE;
      end
    end else if (take) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (pd_q) begin
            if (cls.is_reset) begin
              op_d = OP_RESET;
              pd_d = 1'b0;
            end else if (cls.is_key_a && cls.at_first) begin
              state_d = ST_UNLK1;
            end
          end else begin
            ident_d = 1'b0;
            if (cls.is_reset) begin
              op_d = OP_RESET;
            end else if (cls.is_suspend) begin
              op_d = OP_SUSPEND;
            end else if (cls.is_block) begin
              op_d = OP_RESUME;
            end else if (cls.is_pdown && cls.at_first) begin
              op_d = OP_POWER_DOWN;
              pd_d = 1'b1;
            end else if (cls.is_key_a && cls.at_first) begin
              state_d = ST_UNLK1;
            end
          end
        end
        ST_UNLK1: begin
          if (cls.is_key_b && cls.at_second) begin
            state_d = ST_UNLK2;
          end
        end
        ST_UNLK2: begin
          if (cls.at_first) begin
            if (cls.is_reset) begin
              op_d = OP_RESET;
              pd_d = 1'b0;
            end else if (!pd_q) begin
              if (cls.is_ident) begin
                op_d    = OP_SIGNATURE;
                ident_d = 1'b1;
              end else if (cls.is_prog) begin
                state_d = ST_PROG;
              end else if (cls.is_erase) begin
                state_d = ST_ERA1;
              end
            end
          end
        end
        ST_PROG: begin
          op_d   = OP_PROGRAM;
          addr_d = wr_addr;
          data_d = wr_data;
        end
        ST_ERA1: begin
          if (cls.is_key_a && cls.at_first) begin
            state_d = ST_ERA2;
          end
        end
        ST_ERA2: begin
          if (cls.is_key_b && cls.at_second) begin
            state_d = ST_ERA3;
          end
        end
        ST_ERA3: begin
          if (cls.is_chip && cls.at_first) begin
            op_d = OP_CHIP_ERASE;
          end else if (cls.is_block) begin
            col_start = 1'b1;
            state_d   = ST_COLLECT;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      vld_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      blk_q   <= '0;
      ident_q <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      vld_q   <= (op_d != OP_NONE);
      addr_q  <= addr_d;
      data_q  <= data_d;
      blk_q   <= blk_d;
      ident_q <= ident_d;
      pd_q    <= pd_d;
    end
  end

  assign req_valid    = vld_q;
  assign req_op       = op_q;
  assign req_addr     = addr_q;
  assign req_data     = data_q;
  assign req_blocks   = blk_q;
  assign ident_mode   = ident_q;
  assign powered_down = pd_q;

  AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PROG && take |=> req_valid && req_op == OP_PROGRAM
      && req_addr == $past(wr_addr) && req_data == $past(wr_data)); // R5
  AST_PD_ONLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |=> !req_valid || req_op == OP_RESET); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy && wr_valid && state_q != ST_COLLECT
      && !(ctrl_erase_busy && cls.is_suspend) |=> !req_valid && $stable(state_q)); // R11
  AST_SINGLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    take && state_q == ST_IDLE && cls.is_reset |=> req_valid && req_op == OP_RESET
      && !powered_down && !ident_mode); // R3
  AST_IDENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ident_mode && take |=> !ident_mode || req_op == OP_SIGNATURE); // R4

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int CODE_W       = 15,
  parameter int NUM_BLOCKS   = 8,
  parameter int ERASE_WINDOW = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  ctrl_busy,
  input  logic                  ctrl_erase_busy,
  output logic                  req_valid,
  output logic [3:0]            req_op,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [7:0]            req_data,
  output logic [NUM_BLOCKS-1:0] req_blocks,
  output logic                  ident_mode,
  output logic                  powered_down
);

  logic [1:0]            rst_sync_q;
  logic                  rst_sync_n;
  wr_class_t             cls;
  logic                  col_start;
  logic                  col_add;
  logic                  col_active;
  logic                  col_done;
  logic [NUM_BLOCKS-1:0] col_mask;
  op_e                   op_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  flash_cmd_classify #(
    .CODE_W (CODE_W)
  ) u_classify (
    .code_addr (wr_addr[CODE_W-1:0]),
    .data      (wr_data),
    .cls       (cls)
  );

  flash_blk_collect #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .ERASE_WINDOW (ERASE_WINDOW)
  ) u_collect (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (col_start),
    .add     (col_add),
    .blk_idx (wr_addr[ADDR_W-1 -: BLK_W]),
    .active  (col_active),
    .done    (col_done),
    .mask    (col_mask)
  );

  flash_seq_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .wr_valid        (wr_valid),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .cls             (cls),
    .ctrl_busy       (ctrl_busy),
    .ctrl_erase_busy (ctrl_erase_busy),
    .col_done        (col_done),
    .col_mask        (col_mask),
    .col_start       (col_start),
    .col_add         (col_add),
    .req_valid       (req_valid),
    .req_op          (op_w),
    .req_addr        (req_addr),
    .req_data        (req_data),
    .req_blocks      (req_blocks),
    .ident_mode      (ident_mode),
    .powered_down    (powered_down)
  );

  assign req_op = op_w;

  AST_NO_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    col_active |-> !col_start); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_sync_n |=> !req_valid && !ident_mode && !powered_down); // R1

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int W = 16;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [18:0] wr_addr;
  logic [7:0]  wr_data;
  logic        ctrl_busy;
  logic        ctrl_erase_busy;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [18:0] req_addr;
  logic [7:0]  req_data;
  logic [7:0]  req_blocks;
  logic        ident_mode;
  logic        powered_down;

  int checks;
  int errors;

  flash_cmd_decoder #(.ERASE_WINDOW(W)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_busy(ctrl_busy), .ctrl_erase_busy(ctrl_erase_busy),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_blocks(req_blocks), .ident_mode(ident_mode),
    .powered_down(powered_down)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_req(input string tag, input int op);
    check(tag, int'(req_valid), op != 0 ? 1 : 0);
    if (op != 0) check(tag, int'(req_op), op);
  endtask

  task automatic unlock(input logic [3:0] hi);
    wr({hi, 15'h5555}, 8'hAA);
    expect_req("R10 prefix", 0);
    wr({hi, 15'h2AAA}, 8'h55);
    expect_req("R10 prefix", 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int exp_single(input logic [7:0] d);
    case (d)
      8'hF0:   return 1;
      8'hB0:   return 6;
      8'h30:   return 7;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    checks = 0;
    errors = 0;
    wr_valid = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    ctrl_busy = 1'b0;
    ctrl_erase_busy = 1'b0;
    seed = $urandom(32'h1F2E3D4C);
    do_reset();

    // R1 reset state
    check("R1 req_valid", int'(req_valid), 0);
    check("R1 ident_mode", int'(ident_mode), 0);
    check("R1 powered_down", int'(powered_down), 0);

    // R3 single-cycle reset at arbitrary address
    wr(19'h12345, 8'hF0);
    expect_req("R3 single reset", 1);

    // R2 R3 prefixed reset with high address bits set
    unlock(4'hF);
    wr({4'hA, 15'h5555}, 8'hF0);
    expect_req("R2 R3 prefixed reset", 1);

    // R4 identification mode and its clearing
    unlock(4'h3);
    wr(19'h05555, 8'h90);
    expect_req("R4 ident request", 2);
    check("R4 ident set", int'(ident_mode), 1);
    @(negedge clk);
    check("R4 ident held", int'(ident_mode), 1);
    wr(19'h61234, 8'h00);
    expect_req("R4 plain write", 0);
    check("R4 ident cleared", int'(ident_mode), 0);

    // R5 program capture
    unlock(4'h0);
    wr(19'h05555, 8'hA0);
    expect_req("R5 arm", 0);
    wr(19'h4ABCD, 8'h5A);
    expect_req("R5 program", 3);
    check("R5 addr", int'(req_addr), 32'h4ABCD);
    check("R5 data", int'(req_data), 32'h5A);

    // R6 chip erase
    unlock(4'h0);
    wr(19'h05555, 8'h80);
    unlock(4'h0);
    wr(19'h05555, 8'h10);
    expect_req("R6 chip erase", 5);

    // R7 block window
    unlock(4'h0);
    wr(19'h05555, 8'h80);
    unlock(4'h0);
    wr({3'd2, 16'h1234}, 8'h30);
    expect_req("R7 window open", 0);
    wr(19'h05555, 8'h77);
    expect_req("R7 foreign write ignored", 0);
    wr({3'd5, 16'h0042}, 8'h30);
    expect_req("R7 add block", 0);
    repeat (W - 1) @(negedge clk);
    expect_req("R7 before close", 0);
    @(negedge clk);
    expect_req("R7 block erase", 4);
    check("R7 mask", int'(req_blocks), 32'h24);

    // R8 suspend and resume
    wr(19'h7FFFF, 8'hB0);
    expect_req("R8 suspend", 6);
    wr(19'h00001, 8'h30);
    expect_req("R8 resume", 7);

    // R9 power down
    wr(19'h45555, 8'h20);
    expect_req("R9 power down", 8);
    check("R9 pd set", int'(powered_down), 1);
    wr(19'h00000, 8'hB0);
    expect_req("R9 suspend ignored", 0);
    unlock(4'h0);
    wr(19'h05555, 8'h90);
    expect_req("R9 ident ignored", 0);
    check("R9 ident stays 0", int'(ident_mode), 0);
    check("R9 pd held", int'(powered_down), 1);
    wr(19'h0ABCD, 8'hF0);
    expect_req("R9 reset wakes", 1);
    check("R9 pd cleared", int'(powered_down), 0);
    wr(19'h05555, 8'h20);
    expect_req("R9 power down again", 8);
    unlock(4'h0);
    wr(19'h05555, 8'hF0);
    expect_req("R9 prefixed reset wakes", 1);
    check("R9 pd cleared again", int'(powered_down), 0);

    // R10 mismatches
    wr(19'h05555, 8'hAA);
    wr(19'h02AAB, 8'h55);
    expect_req("R10 bad second address", 0);
    wr(19'h05555, 8'h90);
    expect_req("R10 restart needed", 0);
    check("R10 ident 0", int'(ident_mode), 0);
    unlock(4'h0);
    wr(19'h05554, 8'h90);
    expect_req("R10 bad command address", 0);
    check("R10 ident 0 again", int'(ident_mode), 0);
    unlock(4'h0);
    wr(19'h05555, 8'hA0);
    wr(19'h05555, 8'h00);
    expect_req("R10 program still completes", 3);

    // R11 busy
    ctrl_busy = 1'b1;
    wr(19'h00000, 8'hF0);
    expect_req("R11 reset ignored", 0);
    wr(19'h00000, 8'hB0);
    expect_req("R11 suspend ignored without erase", 0);
    ctrl_erase_busy = 1'b1;
    wr(19'h00000, 8'hB0);
    expect_req("R11 suspend during erase", 6);
    wr(19'h00000, 8'h30);
    expect_req("R11 resume ignored", 0);
    ctrl_busy = 1'b0;
    ctrl_erase_busy = 1'b0;
    unlock(4'h0);
    ctrl_busy = 1'b1;
    wr(19'h05555, 8'hF0);
    expect_req("R11 mid-sequence ignored", 0);
    ctrl_busy = 1'b0;
    wr(19'h05555, 8'h90);
    expect_req("R11 sequence held", 2);
    wr(19'h00000, 8'h00);

    // R1 reset input discards partial sequence
    unlock(4'h0);
    do_reset();
    wr(19'h05555, 8'h90);
    expect_req("R1 partial discarded", 0);
    check("R1 ident after reset", int'(ident_mode), 0);

    // random single writes and program sequences
    for (int i = 0; i < 300; i++) begin
      logic [18:0] a;
      logic [7:0]  d;
      a = 19'($urandom);
      d = 8'($urandom);
      if ($urandom % 4 == 0) begin
        unlock(4'($urandom));
        wr({4'($urandom), 15'h5555}, 8'hA0);
        wr(a, d);
        expect_req("R5 random program", 3);
        check("R5 random addr", int'(req_addr), int'(a));
        check("R5 random data", int'(req_data), int'(d));
      end else begin
        if (d == 8'hAA || d == 8'h20) a[0] = ~a[0] ^ (a[14:0] != 15'h5555);
        if (a[14:0] == 15'h5555 && (d == 8'hAA || d == 8'h20)) a[1] = ~a[1];
        wr(a, d);
        expect_req("R3 R8 random single", exp_single(d));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule